// File: doc/BRIEF.md
# Adaptive Per-Bank Row Close Controller

This block sits beside a DRAM scheduler and decides, for every access the scheduler has just served, whether the row that access opened should be closed at once or left open in the hope that the next access to that bank lands on the same row. For each bank it keeps a small state word: whether a row is open, which row, whether the last decision on the bank was to keep the row open, and how much of that keep-open lifetime remains. A kept row that is not touched again within a programmable lifetime is closed anyway.

The block grades its own keep-open decisions. When a kept row is next accessed at a different row, the keep turned a page-empty access into a page-miss, and a saturating counter records this. At the end of every evaluation interval the count is compared with two programmable thresholds. A high count switches the bank policy from "keep open until the lifetime runs out" to "close unless a queued request targets the same row". A low count switches it back. The counter then restarts. With the adaptive feature disabled, no close request of any kind is produced.

The scheduler presents one served access per cycle, together with a look-ahead flag that says whether any queued request targets that bank and row. Close requests come out as one-cycle pulses, one bit per bank. Issuing the precharge and meeting command timing are left to the scheduler.

Top module: `page_close_ctrl`

## Requirements
- R1: After reset no close request is asserted, the keep-open policy is active and every bank holds no open row, so the first access to a bank is never scored.
- R2: Under the keep-open policy an access is never closed on the spot: close_req stays low in the cycle after the access.
- R3: Under the close policy an access with acc_pend_same low raises close_req bit i (bit i = bank i) for exactly the one cycle after the access edge.
- R4: Under the close policy an access with acc_pend_same high keeps the row open and raises no close request.
- R5: A kept-open row that is not accessed again is closed by a one-cycle close_req pulse exactly life_max+1 clock edges after the access that kept it open. A further access to that bank reloads the lifetime.
- R6: An access to a bank whose row was kept open counts as a bad keep only when its row differs from the open row. A same-row access does not count.
- R7: With the block enabled, the policy is re-evaluated on every eval_len-th clock edge, counted from the first enabled edge, and only then. The bad-keep count restarts from zero after each evaluation.
- R8: At an evaluation under the keep-open policy, a bad-keep count strictly greater than thr_hi selects the close policy.
- R9: At an evaluation under the close policy, a bad-keep count strictly less than thr_lo selects the keep-open policy.
- R10: The bad-keep count saturates at 2^CNT_W-1 and does not wrap.
- R11: While enable is low no close request is produced, either on access or on lifetime expiry. The policy returns to keep-open, the count and interval restart, and all keep-open marks are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Adaptive closing enabled |
| acc_valid | input | 1 | A served access is presented this cycle |
| acc_bank | input | BANK_W | Bank of the served access |
| acc_row | input | ROW_W | Row of the served access |
| acc_pend_same | input | 1 | A queued request targets the same bank and row |
| thr_hi | input | CNT_W | Bad-keep count above which the close policy is chosen |
| thr_lo | input | CNT_W | Bad-keep count below which the keep-open policy is chosen |
| eval_len | input | INT_W | Evaluation interval in clock cycles (0 treated as 1) |
| life_max | input | LIFE_W | Keep-open lifetime in cycles |
| close_req | output | NUM_BANKS | One-cycle close request pulse, bit i for bank i |

## Verification
A wrong bank state word shows up at the ports as a close pulse on the wrong bank, or one that comes a cycle early or late after a keep or a lifetime expiry. It is visible at the latest life_max+1 cycles after the access that set the state. A wrong score or policy cannot be seen directly. It shows only when a probe access with no matching queued request arrives after the next evaluation edge: the access is then closed when it should stay open, or the reverse. The directed scenarios therefore place such probes one edge before and one edge after each evaluation, so that both the threshold and the exact evaluation cycle are checked.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
   typedef enum logic {
      POL_KEEP  = 1'b0,
      POL_CLOSE = 1'b1
   } pcc_policy_e;

   typedef struct packed {
      logic open;
      logic kept;
   } pcc_flags_t;
endpackage

// File: rtl/pcc_bank.sv
module pcc_bank #(
   parameter int ROW_W  = 14,
   parameter int LIFE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                sel,
   input  logic [ROW_W-1:0]    row_in,
   input  logic                pend_same,
   input  pcc_pkg::pcc_policy_e pol,
   input  logic [LIFE_W-1:0]   life_max,
   output logic                close_pulse,
   output logic                bad_keep_evt
);
   import pcc_pkg::*;

   pcc_flags_t        flags;
   logic [ROW_W-1:0]  row_q;
   logic [LIFE_W-1:0] life_q;
   logic              row_hit;
   logic              do_close;
   logic              expire;

   always_comb begin
      row_hit      = flags.open && (row_q == row_in);
      bad_keep_evt = en && sel && flags.open && flags.kept && !row_hit;
      do_close     = en && sel && (pol == POL_CLOSE) && !pend_same;
      expire       = en && !sel && flags.open && flags.kept && (life_q == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags       <= '0;
         row_q       <= '0;
         life_q      <= '0;
         close_pulse <= 1'b0;
      end else begin
         close_pulse <= do_close || expire;
         if (!en) begin
            flags.kept <= 1'b0;
            if (sel) begin
               flags.open <= 1'b1;
               row_q      <= row_in;
            end
         end else if (sel) begin
            row_q <= row_in;
            if (do_close) begin
               flags.open <= 1'b0;
               flags.kept <= 1'b0;
            end else begin
               flags.open <= 1'b1;
               flags.kept <= 1'b1;
               life_q     <= life_max;
            end
         end else if (expire) begin
            flags.open <= 1'b0;
            flags.kept <= 1'b0;
         end else if (flags.kept && (life_q != '0)) begin
            life_q <= life_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pcc_policy.sv
module pcc_policy #(
   parameter int CNT_W = 8,
   parameter int INT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 bad_evt,
   input  logic [CNT_W-1:0]     thr_hi,
   input  logic [CNT_W-1:0]     thr_lo,
   input  logic [INT_W-1:0]     eval_len,
   output pcc_pkg::pcc_policy_e pol,
   output logic                 eval_now
);
   import pcc_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [INT_W-1:0] tick_q;
   logic [CNT_W-1:0] bad_q;

   assign eval_now = en && (({1'b0, tick_q} + 1'b1) >= {1'b0, eval_len});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_q <= '0;
         bad_q  <= '0;
         pol    <= POL_KEEP;
      end else if (!en) begin
         tick_q <= '0;
         bad_q  <= '0;
         pol    <= POL_KEEP;
      end else if (eval_now) begin
         tick_q <= '0;
         bad_q  <= '0;
         if ((pol == POL_KEEP) && (bad_q > thr_hi))
            pol <= POL_CLOSE;
         else if ((pol == POL_CLOSE) && (bad_q < thr_lo))
            pol <= POL_KEEP;
      end else begin
         tick_q <= tick_q + 1'b1;
         if (bad_evt && (bad_q != CNT_MAX))
            bad_q <= bad_q + 1'b1;
      end
   end
endmodule

// File: rtl/page_close_ctrl.sv
module page_close_ctrl #(
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 14,
   parameter int CNT_W     = 8,
   parameter int INT_W     = 16,
   parameter int LIFE_W    = 8,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 acc_valid,
   input  logic [BANK_W-1:0]    acc_bank,
   input  logic [ROW_W-1:0]     acc_row,
   input  logic                 acc_pend_same,
   input  logic [CNT_W-1:0]     thr_hi,
   input  logic [CNT_W-1:0]     thr_lo,
   input  logic [INT_W-1:0]     eval_len,
   input  logic [LIFE_W-1:0]    life_max,
   output logic [NUM_BANKS-1:0] close_req
);
   import pcc_pkg::*;

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (ROW_W < 1 || CNT_W < 2 || INT_W < 2 || LIFE_W < 1) begin : g_bad_widths
      $error("field widths out of range");
   end

   pcc_policy_e         pol;
   logic                eval_now;
   logic [NUM_BANKS-1:0] bad_vec;
   logic                bad_any;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel_b;
      assign sel_b = acc_valid && (acc_bank == BANK_W'(b));
      pcc_bank #(
         .ROW_W  (ROW_W),
         .LIFE_W (LIFE_W)
      ) u_bank (
         .clk          (clk),
         .rst_n        (rst_n),
         .en           (enable),
         .sel          (sel_b),
         .row_in       (acc_row),
         .pend_same    (acc_pend_same),
         .pol          (pol),
         .life_max     (life_max),
         .close_pulse  (close_req[b]),
         .bad_keep_evt (bad_vec[b])
      );
   end

   assign bad_any = |bad_vec;

   pcc_policy #(
      .CNT_W (CNT_W),
      .INT_W (INT_W)
   ) u_policy (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (enable),
      .bad_evt  (bad_any),
      .thr_hi   (thr_hi),
      .thr_lo   (thr_lo),
      .eval_len (eval_len),
      .pol      (pol),
      .eval_now (eval_now)
   );
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
   parameter int NUM_BANKS = 8,
   parameter int BANK_W    = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 enable,
   input logic                 acc_valid,
   input logic [BANK_W-1:0]    acc_bank,
   input logic                 acc_pend_same,
   input logic [NUM_BANKS-1:0] close_req,
   input logic                 pol_close,
   input logic                 eval_now
);
   assert_keep_policy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && acc_valid && !pol_close) |=> !close_req[$past(acc_bank)]);

   assert_close_policy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && acc_valid && pol_close && !acc_pend_same) |=> close_req[$past(acc_bank)]);

   assert_pend_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && acc_valid && acc_pend_same) |=> !close_req[$past(acc_bank)]);

   assert_policy_only_at_eval_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !eval_now) |=> $stable(pol_close));

   assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (close_req == '0) && !pol_close);
endmodule

bind page_close_ctrl pcc_checker #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable        (enable),
   .acc_valid     (acc_valid),
   .acc_bank      (acc_bank),
   .acc_pend_same (acc_pend_same),
   .close_req     (close_req),
   .pol_close     (pol),
   .eval_now      (eval_now)
);

// File: tb/page_close_ctrl_bench.sv
module page_close_ctrl_bench;
   localparam int NB = 8;
   localparam int BW = 3;
   localparam int RW = 14;
   localparam int CW = 8;
   localparam int IW = 16;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          acc_valid = 1'b0;
   logic [BW-1:0] acc_bank = '0;
   logic [RW-1:0] acc_row = '0;
   logic          acc_pend_same = 1'b0;
   logic [CW-1:0] thr_hi = '0;
   logic [CW-1:0] thr_lo = '0;
   logic [IW-1:0] eval_len = 16'd100;
   logic [LW-1:0] life_max = 8'd200;
   logic [NB-1:0] close_req;

   int checks = 0;
   int errors = 0;

   always #10ns clk = ~clk;

   page_close_ctrl u_page_close_ctrl (
      .clk(clk), .rst_n(rst_n), .enable(enable), .acc_valid(acc_valid),
      .acc_bank(acc_bank), .acc_row(acc_row), .acc_pend_same(acc_pend_same),
      .thr_hi(thr_hi), .thr_lo(thr_lo), .eval_len(eval_len),
      .life_max(life_max), .close_req(close_req)
   );

   task automatic tick();
      @(posedge clk);
      #1ns;
   endtask

   task automatic expect_req(input logic [NB-1:0] exp, input string tag);
      checks++;
      if (close_req !== exp) begin
         errors++;
         $display("FAIL %s: close_req actual %b expected %b", tag, close_req, exp);
      end
   endtask

   task automatic access(input int bank, input int row, input logic pend);
      acc_valid     = 1'b1;
      acc_bank      = BW'(bank);
      acc_row       = RW'(row);
      acc_pend_same = pend;
      tick();
      acc_valid     = 1'b0;
      acc_pend_same = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   // Disable for one edge; the next edge is enabled edge 1.
   task automatic restart(input int ilen, input int hi, input int lo, input int life);
      enable   = 1'b0;
      eval_len = IW'(ilen);
      thr_hi   = CW'(hi);
      thr_lo   = CW'(lo);
      life_max = LW'(life);
      tick();
      enable = 1'b1;
   endtask

   // R1, R6, R7, R8: scoring from reset state and exact evaluation edge
   task automatic t_reset_and_scoring();
      expect_req('0, "R1 reset");
      restart(8, 0, 0, 200);
      access(0, 9, 1'b0);                // edge 1: no prior row, not scored
      expect_req('0, "R2 keep on first access");
      idle(7);                           // edges 2..8, eval at 8
      access(1, 1, 1'b0);                // edge 9
      expect_req('0, "R1 first access unscored");
      access(0, 9, 1'b0);                // edge 10: same row, not bad
      idle(6);                           // edges 11..16, eval
      access(4, 2, 1'b0);                // edge 17
      expect_req('0, "R6 same-row not scored");
      access(0, 10, 1'b0);               // edge 18: bad keep = 1
      idle(4);                           // edges 19..22
      access(6, 3, 1'b0);                // edge 23, before eval
      expect_req('0, "R7 no switch before eval edge");
      idle(1);                           // edge 24: eval, 1 > 0
      access(5, 4, 1'b0);                // edge 25
      expect_req(8'h20, "R8 switch after eval");
   endtask

   // R2, R3, R4, R8, R9
   task automatic t_policy_switching();
      restart(16, 2, 1, 200);
      access(0, 5, 1'b0);                // edge 1
      expect_req('0, "R2 keep-open policy");
      access(0, 6, 1'b0);
      access(0, 7, 1'b0);
      access(0, 8, 1'b0);                // edge 4: bad = 3
      idle(10);                          // edges 5..14
      access(1, 1, 1'b0);                // edge 15
      expect_req('0, "R8 unchanged before eval");
      idle(1);                           // edge 16: eval, 3 > 2
      access(2, 3, 1'b0);                // edge 17
      expect_req(8'h04, "R3 close pulse");
      idle(1);                           // edge 18
      expect_req('0, "R3 pulse one cycle");
      access(2, 4, 1'b1);                // edge 19
      expect_req('0, "R4 pending same row keeps");
      idle(13);                          // edges 20..32, eval: 0 < 1
      access(3, 1, 1'b0);                // edge 33
      expect_req('0, "R9 back to keep-open");
   endtask

   // R5: lifetime expiry and reload
   task automatic t_lifetime();
      restart(1000, 255, 0, 5);
      access(3, 7, 1'b0);                // edge 1
      idle(5);                           // edges 2..6
      expect_req('0, "R5 not before lifetime");
      idle(1);                           // edge 7
      expect_req(8'h08, "R5 expiry close");
      idle(1);
      expect_req('0, "R5 expiry pulse one cycle");
      access(3, 7, 1'b0);                // edge 1'
      idle(3);                           // edges 2'..4'
      access(3, 7, 1'b0);                // edge 5': reload
      idle(5);                           // edges 6'..10'
      expect_req('0, "R5 reload delays expiry");
      idle(1);                           // edge 11'
      expect_req(8'h08, "R5 expiry after reload");
   endtask

   // R10: saturation of the bad-keep count
   task automatic t_saturation();
      restart(400, 254, 0, 255);
      for (int i = 0; i < 301; i++) access(0, i, 1'b0); // 300 bad keeps
      idle(99);                          // edges 302..400, eval
      access(1, 5, 1'b0);                // edge 401
      expect_req(8'h02, "R10 saturated count exceeds threshold");
   endtask

   // R11: disabled operation
   task automatic t_disabled();
      enable = 1'b0;                     // close policy was active
      life_max = 8'd2;
      access(2, 9, 1'b0);
      expect_req('0, "R11 no close when disabled");
      access(6, 1, 1'b0);
      for (int i = 0; i < 6; i++) begin
         tick();
         expect_req('0, "R11 no expiry when disabled");
      end
      restart(1000, 255, 0, 2);
      access(2, 9, 1'b0);                // edge 1
      expect_req('0, "R11 policy back to keep-open");
      idle(2);
      expect_req('0, "R11 kept mark cleared on bank 6");
      idle(1);                           // edge 4: bank 2 lifetime 2 expires
      expect_req(8'h04, "R11 bank 2 expiry after re-enable");
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset_and_scoring();
      t_policy_switching();
      t_lifetime();
      t_saturation();
      t_disabled();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule